// File: doc/BRIEF.md
# Vector Length Setting Unit

This block takes the 12-bit vector-length control field carried by a long prefixed instruction and uses it to update a local 32-bit vector state word. The word holds the current vector length (VL), its upper limit (MAXVL), the source and destination element offsets, a sub-vector length and a sub-vector offset. The field selects one of four actions. It can leave the state alone, load VL from an immediate, load VL from a scalar register clamped to MAXVL, or set MAXVL from an immediate and either set VL to the same value or shrink VL to fit under it.

A second 5-bit field names a scalar destination register. When that field is non-zero, the block issues a write-back request one cycle later that carries the new VL. The register named by the field is looked up outside the block: the unit presents its index and receives the value in the same cycle.

A CSR-style port lets software read the whole state word and write it. Encodings that are not allowed raise an illegal flag and change nothing.

Top module: `vlset_unit`

## Requirements
- R1: After reset the state word reads as zero and wb_valid, cmd_illegal and csr_illegal are all low.
- R2: An all-zero control field with cmd_valid changes no state, issues no write-back and raises no illegal flag.
- R3: With field bit 11 = 0 and bit 0 = 0, VL becomes min(imm+1, MAXVL), where imm is field bits 5:1; MAXVL is unchanged.
- R4: With bit 11 = 0 and bit 0 = 1, src_idx shows field bits 5:1 and VL becomes min(src_val, MAXVL); MAXVL is unchanged; index 0 is illegal.
- R5: With bit 11 = 1 and bit 0 = 0, both MAXVL and VL become imm+1.
- R6: With bit 11 = 1 and bit 0 = 1, MAXVL becomes imm+1 and VL becomes min(old VL, imm+1).
- R7: Field bits 10:6 name the destination register. After a state-changing command with a non-zero destination, the next cycle shows wb_valid high, wb_idx equal to that index and wb_data equal to the new VL, zero-extended. A destination of 0 gives no write-back.
- R8: Every state-changing command clears srcoffs and destoffs and keeps subvl and dsvoffs.
- R9: An illegal command pulses cmd_illegal in the next cycle and leaves the state word and the write-back port unchanged.
- R10: The state word has maxvl in bits 5:0, vl in 11:6, srcoffs in 17:12, destoffs in 23:18, subvl in 25:24 and dsvoffs in 27:26, and bits 31:28 always read as zero. A write with any of bits 31:28 set is rejected: csr_illegal pulses in the next cycle and the state is kept. Any other write loads the word.
- R11: When csr_we and cmd_valid are high in the same cycle, the CSR write is applied and the command is ignored, with no write-back and no cmd_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Control field is present this cycle |
| cmd_field | input | 12 | Vector-length control field |
| src_idx | output | 5 | Index of the scalar register the field names |
| src_val | input | XLEN | Value of the register at src_idx |
| wb_valid | output | 1 | Write-back request |
| wb_idx | output | 5 | Write-back destination register |
| wb_data | output | XLEN | Write-back value (new VL) |
| cmd_illegal | output | 1 | Illegal command pulse |
| csr_we | input | 1 | State word write strobe |
| csr_wdata | input | 32 | State word write data |
| csr_rdata | output | 32 | State word read data |
| csr_illegal | output | 1 | Rejected state-word write pulse |

## Verification
A wrong VL or MAXVL shows up on csr_rdata in the cycle after the command. When a destination is given, the wrong value also appears on wb_data in that same cycle. A wrong MAXVL can also stay hidden until a later clamped update gives a different length, so the bench runs long random sequences of commands against a cycle-accurate model. A missed offset clear or a leaked reserved bit appears on csr_rdata at once, and the bench compares that word after every cycle.

// File: rtl/vlset_pkg.sv
package vlset_pkg;
  localparam int LEN_W = 6;
  localparam int IDX_W = 5;
  localparam int CTL_W = 12;
  localparam int RSV_W = 4;

  typedef struct packed {
    logic [RSV_W-1:0] rsvd;
    logic [1:0]       dsvoffs;
    logic [1:0]       subvl;
    logic [LEN_W-1:0] destoffs;
    logic [LEN_W-1:0] srcoffs;
    logic [LEN_W-1:0] vl;
    logic [LEN_W-1:0] maxvl;
  } vstate_t;

  function automatic logic [LEN_W-1:0] imm_len(input logic [IDX_W-1:0] imm);
    return {1'b0, imm} + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/vlset_decode.sv
module vlset_decode
  import vlset_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CTL_W-1:0] field,
  input  logic [LEN_W-1:0] cur_vl,
  input  logic [LEN_W-1:0] cur_max,
  input  logic [XLEN-1:0]  src_val,
  output logic             is_nop,
  output logic             is_bad,
  output logic [LEN_W-1:0] new_vl,
  output logic [LEN_W-1:0] new_max,
  output logic [IDX_W-1:0] dest_idx,
  output logic [IDX_W-1:0] src_idx
);
  logic [IDX_W-1:0] imm;
  logic [LEN_W-1:0] src_len;
  logic             src_big;

  assign imm      = field[IDX_W:1];
  assign src_idx  = imm;
  assign dest_idx = field[CTL_W-2:IDX_W+1];
  assign src_big  = |src_val[XLEN-1:LEN_W];
  assign src_len  = src_big ? {LEN_W{1'b1}} : src_val[LEN_W-1:0];
  assign is_nop   = (field == '0);

  always_comb begin
    is_bad  = 1'b0;
    new_vl  = cur_vl;
    new_max = cur_max;
    unique case ({field[CTL_W-1], field[0]})
      2'b00: new_vl = min_len(imm_len(imm), cur_max);
      2'b01: begin
        is_bad = (imm == '0);
        new_vl = min_len(src_len, cur_max);
      end
      2'b10: begin
        new_max = imm_len(imm);
        new_vl  = imm_len(imm);
      end
      default: begin
        new_max = imm_len(imm);
        new_vl  = min_len(cur_vl, imm_len(imm));
      end
    endcase
  end
endmodule

// File: rtl/vlset_state.sv
module vlset_state
  import vlset_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [LEN_W-1:0] upd_vl,
  input  logic [LEN_W-1:0] upd_max,
  input  logic             wr,
  input  logic [31:0]      wr_data,
  output vstate_t          state_q
);
  vstate_t wr_word;

  always_comb begin
    wr_word      = vstate_t'(wr_data);
    wr_word.rsvd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (wr) begin
      state_q <= wr_word;
    end else if (upd) begin
      state_q.vl       <= upd_vl;
      state_q.maxvl    <= upd_max;
      state_q.srcoffs  <= '0;
      state_q.destoffs <= '0;
    end
  end
endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
  import vlset_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CTL_W-1:0] cmd_field,
  output logic [IDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]  src_val,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]  wb_data,
  output logic             cmd_illegal,
  input  logic             csr_we,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  output logic             csr_illegal
);
  vstate_t          st;
  logic             dec_nop, dec_bad;
  logic [LEN_W-1:0] dec_vl, dec_max;
  logic [IDX_W-1:0] dest_idx;
  logic             cmd_take, cmd_upd, csr_bad, csr_ok;

  vlset_decode #(.XLEN(XLEN)) u_dec (
    .field(cmd_field), .cur_vl(st.vl), .cur_max(st.maxvl), .src_val(src_val),
    .is_nop(dec_nop), .is_bad(dec_bad), .new_vl(dec_vl), .new_max(dec_max),
    .dest_idx(dest_idx), .src_idx(src_idx)
  );

  assign cmd_take = cmd_valid && !csr_we;
  assign cmd_upd  = cmd_take && !dec_nop && !dec_bad;
  assign csr_bad  = csr_we && (|csr_wdata[31:32-RSV_W]);
  assign csr_ok   = csr_we && !csr_bad;

  vlset_state u_st (
    .clk(clk), .rst_n(rst_n), .upd(cmd_upd), .upd_vl(dec_vl), .upd_max(dec_max),
    .wr(csr_ok), .wr_data(csr_wdata), .state_q(st)
  );

  assign csr_rdata = 32'(st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid    <= 1'b0;
      wb_idx      <= '0;
      wb_data     <= '0;
      cmd_illegal <= 1'b0;
      csr_illegal <= 1'b0;
    end else begin
      wb_valid    <= cmd_upd && (dest_idx != '0);
      wb_idx      <= dest_idx;
      wb_data     <= XLEN'(dec_vl);
      cmd_illegal <= cmd_take && dec_bad;
      csr_illegal <= csr_bad;
    end
  end
endmodule

// File: rtl/vlset_checks.sv
module vlset_checks #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_upd,
  input logic            cmd_illegal,
  input logic            csr_illegal,
  input logic            wb_valid,
  input logic [4:0]      wb_idx,
  input logic [XLEN-1:0] wb_data,
  input logic [31:0]     csr_rdata
);
  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[31:28] == 4'h0);

  assert_wb_is_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data == XLEN'(csr_rdata[11:6])) && (wb_idx != 5'd0));

  assert_bad_cmd_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> $stable(csr_rdata) && !wb_valid);

  assert_bad_csr_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> $stable(csr_rdata));

  assert_offs_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_upd |=> csr_rdata[23:12] == 12'h000);
endmodule

bind vlset_unit vlset_checks #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_upd(cmd_upd), .cmd_illegal(cmd_illegal),
  .csr_illegal(csr_illegal), .wb_valid(wb_valid), .wb_idx(wb_idx),
  .wb_data(wb_data), .csr_rdata(csr_rdata)
);

// File: tb/sim_vlset_unit.sv
module sim_vlset_unit;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid;
  logic [11:0]     cmd_field;
  logic [4:0]      src_idx;
  logic [XLEN-1:0] src_val;
  logic            wb_valid;
  logic [4:0]      wb_idx;
  logic [XLEN-1:0] wb_data;
  logic            cmd_illegal;
  logic            csr_we;
  logic [31:0]     csr_wdata;
  logic [31:0]     csr_rdata;
  logic            csr_illegal;

  int checks = 0;
  int errors = 0;

  // model state
  int m_max = 0, m_vl = 0, m_src = 0, m_dst = 0, m_sub = 0, m_dsv = 0;

  always #10 clk = ~clk;

  vlset_unit #(.XLEN(XLEN)) u0 (.*);

  function automatic logic [31:0] model_word();
    return {4'h0, 2'(m_dsv), 2'(m_sub), 6'(m_dst), 6'(m_src), 6'(m_vl), 6'(m_max)};
  endfunction

  function automatic logic [11:0] mk(input bit top, input int dst, input int imm, input bit low);
    return {top, 5'(dst), 5'(imm), low};
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, check after the next falling edge
  task automatic step(input bit v, input logic [11:0] f, input logic [31:0] sv,
                      input bit we, input logic [31:0] wd, input string tag);
    bit e_wb = 0, e_ci = 0, e_csri = 0;
    int e_wi = 0, e_wd = 0, imm, dst, nvl, nmax;
    cmd_valid = v; cmd_field = f; src_val = sv; csr_we = we; csr_wdata = wd;
    #1;
    if (v) chk(tag, "src_idx", src_idx, f[5:1]);
    imm = f[5:1]; dst = f[10:6];
    if (we) begin
      if (wd[31:28] != 0) e_csri = 1;
      else begin
        m_max = wd[5:0]; m_vl = wd[11:6]; m_src = wd[17:12];
        m_dst = wd[23:18]; m_sub = wd[25:24]; m_dsv = wd[27:26];
      end
    end else if (v && f != 0) begin
      if (!f[11] && f[0] && imm == 0) e_ci = 1;
      else begin
        nmax = m_max;
        if (!f[11] && !f[0]) nvl = (imm + 1 < m_max) ? imm + 1 : m_max;
        else if (!f[11]) nvl = (sv < 32'(m_max)) ? int'(sv) : m_max;
        else if (!f[0]) begin nmax = imm + 1; nvl = imm + 1; end
        else begin nmax = imm + 1; nvl = (m_vl < nmax) ? m_vl : nmax; end
        m_max = nmax; m_vl = nvl; m_src = 0; m_dst = 0;
        if (dst != 0) begin e_wb = 1; e_wi = dst; e_wd = nvl; end
      end
    end
    @(negedge clk);
    chk(tag, "csr_rdata", csr_rdata, model_word());
    chk(tag, "wb_valid", wb_valid, e_wb);
    if (e_wb) begin
      chk(tag, "wb_idx", wb_idx, e_wi);
      chk(tag, "wb_data", wb_data, e_wd);
    end
    chk(tag, "cmd_illegal", cmd_illegal, e_ci);
    chk(tag, "csr_illegal", csr_illegal, e_csri);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_field = '0; src_val = '0; csr_we = 0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "csr_rdata", csr_rdata, 0);
    chk("R1", "wb_valid", wb_valid, 0);
    chk("R1", "cmd_illegal", cmd_illegal, 0);
    chk("R1", "csr_illegal", csr_illegal, 0);
    step(1, 12'h000, 0, 0, 0, "R2");
    step(1, mk(1, 3, 7, 0), 0, 0, 0, "R5");          // max=vl=8, wb x3
    step(1, mk(0, 0, 3, 0), 0, 0, 0, "R3");          // vl=4
    step(1, mk(0, 9, 20, 0), 0, 0, 0, "R3");         // clamp to 8, R7 wb
    step(0, 0, 0, 1, {4'h0, 2'd2, 2'd3, 6'd5, 6'd9, 6'd6, 6'd8}, "R10");
    step(1, mk(0, 1, 1, 0), 0, 0, 0, "R8");          // offsets cleared
    step(1, mk(0, 2, 5, 1), 32'd3, 0, 0, "R4");      // vl=3
    step(1, mk(0, 2, 5, 1), 32'd100000, 0, 0, "R4"); // clamp 8
    step(1, mk(0, 4, 0, 1), 32'd2, 0, 0, "R9");      // x0 illegal
    step(1, mk(1, 7, 1, 1), 0, 0, 0, "R6");          // max 2, vl 2
    step(1, mk(1, 0, 30, 1), 0, 0, 0, "R6");         // max 31, vl 2
    step(0, 0, 0, 1, 32'h1000_0041, "R10");          // reserved -> reject
    step(1, mk(1, 5, 9, 0), 0, 1, 32'h0000_0145, "R11");
    step(1, mk(0, 0, 0, 1), 0, 1, 32'h0000_0003, "R11");
    for (int i = 0; i < 400; i++) begin
      logic [11:0] f = 12'($urandom);
      bit we = ($urandom % 10) == 0;
      logic [31:0] wd = $urandom;
      if (($urandom % 3) != 0) wd[31:28] = 0;
      if (($urandom % 16) == 0) f = 0;
      step(($urandom % 4) != 0, f, ($urandom % 2) ? $urandom % 64 : $urandom, we, wd, "R7");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule